// File: doc/BRIEF.md
# Banked SRAM Set Decoder

This block turns a 24-bit byte address from a 16-bit memory bus into chip selects for eight banks of byte-wide static RAM. Each bank holds 2MB as a pair of chips: one on the low byte lane and one on the high byte lane. The bank number is taken from the top three address bits. The word index inside the chip pair is passed on to the chips, registered.

Banks 1 to 4 (indices 0 to 3) are always part of the linear extended-memory map. Banks 5 to 8 (indices 4 to 7) can play two roles. While expanded-memory mode is off, a populated upper bank simply extends the linear map. When expanded-memory mode is on and a bank is claimed for the expanded pool, that bank leaves the linear map. From then on it is reached only through the page mapper, which names the bank directly.

A parameter mask records which banks are fitted. An access to a bank that is not fitted selects nothing and is reported as unclaimed. A per-bank flag tells whether each bank currently counts as usable extended memory. All outputs are registered, one cycle after the inputs.

Top module: `sram_set_decoder`

## Requirements
- R1: While rst_n is low, and on the first edge after it, every chip select, claimed, xms_usable and word_addr are zero.
- R2: With req high and map_req low, the bank index addr[23:21] is decoded. Bank index k drives cs_lo[k] and/or cs_hi[k] at the clock edge after the request, provided the bank is populated and not withdrawn.
- R3: The low-lane select is active only when addr[0] is 0. The high-lane select is active only when bhe_n is 0. Both can be active together.
- R4: A bank whose bit in the POPULATED mask is 0 is never selected, and claimed stays 0 for accesses to it. The default mask is 8'b0011_0001 (indices 0, 4 and 5).
- R5: While ems_mode is 0, the ems_claim inputs have no effect on selects or on xms_usable.
- R6: While ems_mode is 1, a bank with index 4 to 7 whose ems_claim bit is 1 is not selected by a linear access.
- R7: ems_claim bits 0 to 3 have no effect in any mode.
- R8: With map_req high, bank map_set is selected only if it is populated, has index 4 to 7, is claimed, and ems_mode is 1. Otherwise nothing is selected. addr[23:21] is ignored on a mapper access.
- R9: When req and map_req are both high in the same cycle, only the mapper decode is used.
- R10: xms_usable[k] is 1 exactly when bank k is populated and not withdrawn by R6, registered one cycle.
- R11: claimed is 1 when a bank was hit, even if no lane is enabled. At most one bank drives any select at a time.
- R12: word_addr equals addr[20:1] of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Linear memory access this cycle |
| addr | input | 24 | Byte address; [23:21] bank, [20:1] word, [0] low lane |
| bhe_n | input | 1 | Active-low high byte enable |
| map_req | input | 1 | Page-mapper access this cycle |
| map_set | input | 3 | Bank index chosen by the page mapper |
| ems_mode | input | 1 | Expanded-memory mode active |
| ems_claim | input | 8 | Per-bank claim for the expanded pool |
| cs_lo | output | 8 | Low byte chip selects, active high |
| cs_hi | output | 8 | High byte chip selects, active high |
| claimed | output | 1 | Some bank responded to the access |
| xms_usable | output | 8 | Bank counts as linear extended memory |
| word_addr | output | 20 | Word index to the chip pair |

## Verification
A linear request and a mapper request can arrive in the same cycle. The mapper must win even when the linear address points at a different, fully valid bank. The bench drives both strobes together, with the linear address on a populated, unclaimed bank and map_set on a claimed pool bank. It then checks that only the mapper's bank is selected. It repeats this with a mapper target that is rejected, and checks that the linear bank does not slip through in its place.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;

  typedef struct packed {
    logic lo;
    logic hi;
  } lane_t;

  // Byte lanes of a 16-bit access: low on even address, high on enable.
  function automatic lane_t lanes_of(input logic a0, input logic bhe_n);
    lane_t l;
    l.lo = ~a0;
    l.hi = ~bhe_n;
    return l;
  endfunction

  // A claim only counts for dual-role banks while expanded mode is on.
  function automatic logic claim_effective(input logic ems_mode,
                                           input logic claim_bit,
                                           input logic is_dual);
    return ems_mode & claim_bit & is_dual;
  endfunction

endpackage

// File: rtl/sram_linear_dec.sv
module sram_linear_dec
  import sram_dec_pkg::*;
#(
  parameter int SET_W = 3,
  parameter int FIRST_DUAL = 4,
  parameter logic [(1<<SET_W)-1:0] POPULATED = '1
) (
  input  logic                     req,
  input  logic [SET_W-1:0]         set_idx,
  input  logic                     ems_mode,
  input  logic [(1<<SET_W)-1:0]    ems_claim,
  output logic [(1<<SET_W)-1:0]    lin_hit,
  output logic [(1<<SET_W)-1:0]    usable
);
  localparam int N_SETS = 1 << SET_W;

  for (genvar i = 0; i < N_SETS; i++) begin : g_set
    localparam logic IS_DUAL = (i >= FIRST_DUAL);
    logic withdrawn;
    always_comb begin
      withdrawn  = claim_effective(ems_mode, ems_claim[i], IS_DUAL);
      usable[i]  = POPULATED[i] & ~withdrawn;
      lin_hit[i] = req & (set_idx == SET_W'(i)) & usable[i];
    end
  end

endmodule

// File: rtl/sram_map_dec.sv
module sram_map_dec
  import sram_dec_pkg::*;
#(
  parameter int SET_W = 3,
  parameter int FIRST_DUAL = 4,
  parameter logic [(1<<SET_W)-1:0] POPULATED = '1
) (
  input  logic                     map_req,
  input  logic [SET_W-1:0]         map_set,
  input  logic                     ems_mode,
  input  logic [(1<<SET_W)-1:0]    ems_claim,
  output logic [(1<<SET_W)-1:0]    map_hit
);
  localparam int N_SETS = 1 << SET_W;

  for (genvar i = 0; i < N_SETS; i++) begin : g_set
    localparam logic IS_DUAL = (i >= FIRST_DUAL);
    always_comb
      map_hit[i] = map_req & (map_set == SET_W'(i)) & POPULATED[i]
                   & claim_effective(ems_mode, ems_claim[i], IS_DUAL);
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_dec_pkg::*;
#(
  parameter int N_SETS = 8,
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SETS-1:0] sel_d,
  input  lane_t             lanes_d,
  input  logic [N_SETS-1:0] usable_d,
  input  logic [WORD_W-1:0] word_d,
  output logic [N_SETS-1:0] cs_lo,
  output logic [N_SETS-1:0] cs_hi,
  output logic              claimed,
  output logic [N_SETS-1:0] xms_usable,
  output logic [WORD_W-1:0] word_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_lo      <= '0;
      cs_hi      <= '0;
      claimed    <= 1'b0;
      xms_usable <= '0;
      word_addr  <= '0;
    end else begin
      cs_lo      <= sel_d & {N_SETS{lanes_d.lo}};
      cs_hi      <= sel_d & {N_SETS{lanes_d.hi}};
      claimed    <= |sel_d;
      xms_usable <= usable_d;
      word_addr  <= word_d;
    end
  end

endmodule

// File: rtl/sram_set_decoder.sv
module sram_set_decoder
  import sram_dec_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W = 3,
  parameter int FIRST_DUAL = 4,
  parameter logic [(1<<SET_W)-1:0] POPULATED = 8'b0011_0001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     bhe_n,
  input  logic                     map_req,
  input  logic [SET_W-1:0]         map_set,
  input  logic                     ems_mode,
  input  logic [(1<<SET_W)-1:0]    ems_claim,
  output logic [(1<<SET_W)-1:0]    cs_lo,
  output logic [(1<<SET_W)-1:0]    cs_hi,
  output logic                     claimed,
  output logic [(1<<SET_W)-1:0]    xms_usable,
  output logic [ADDR_W-SET_W-2:0]  word_addr
);
  localparam int N_SETS = 1 << SET_W;
  localparam int WORD_W = ADDR_W - SET_W - 1;

  logic [SET_W-1:0]  set_idx;
  logic [N_SETS-1:0] lin_hit;
  logic [N_SETS-1:0] map_hit;
  logic [N_SETS-1:0] usable_d;
  logic [N_SETS-1:0] sel_d;   // bank chosen this cycle, brought out for checks
  lane_t             lanes_d;

  assign set_idx = addr[ADDR_W-1 -: SET_W];
  assign lanes_d = lanes_of(addr[0], bhe_n);
  // Mapper access owns the cycle; linear decode is dropped.
  assign sel_d   = map_req ? map_hit : lin_hit;

  sram_linear_dec #(.SET_W(SET_W), .FIRST_DUAL(FIRST_DUAL), .POPULATED(POPULATED)) u_lin (
    .req(req), .set_idx(set_idx), .ems_mode(ems_mode), .ems_claim(ems_claim),
    .lin_hit(lin_hit), .usable(usable_d)
  );

  sram_map_dec #(.SET_W(SET_W), .FIRST_DUAL(FIRST_DUAL), .POPULATED(POPULATED)) u_map (
    .map_req(map_req), .map_set(map_set), .ems_mode(ems_mode), .ems_claim(ems_claim),
    .map_hit(map_hit)
  );

  sram_out_stage #(.N_SETS(N_SETS), .WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .sel_d(sel_d), .lanes_d(lanes_d), .usable_d(usable_d),
    .word_d(addr[WORD_W:1]), .cs_lo(cs_lo), .cs_hi(cs_hi), .claimed(claimed),
    .xms_usable(xms_usable), .word_addr(word_addr)
  );

endmodule

// File: rtl/sram_set_decoder_chk.sv
module sram_set_decoder_chk #(
  parameter int ADDR_W = 24,
  parameter int SET_W = 3,
  parameter int FIRST_DUAL = 4,
  parameter logic [(1<<SET_W)-1:0] POPULATED = 8'b0011_0001
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req,
  input logic [ADDR_W-1:0]       addr,
  input logic                    bhe_n,
  input logic                    map_req,
  input logic [SET_W-1:0]        map_set,
  input logic                    ems_mode,
  input logic [(1<<SET_W)-1:0]   ems_claim,
  input logic [(1<<SET_W)-1:0]   cs_lo,
  input logic [(1<<SET_W)-1:0]   cs_hi,
  input logic                    claimed,
  input logic [(1<<SET_W)-1:0]   xms_usable,
  input logic [ADDR_W-SET_W-2:0] word_addr,
  input logic [(1<<SET_W)-1:0]   sel_d
);
  logic [SET_W-1:0] a_set;
  assign a_set = addr[ADDR_W-1 -: SET_W];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cs_lo == '0 && cs_hi == '0 && !claimed && xms_usable == '0));

  assert_lo_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr[0] |=> cs_lo == '0);

  assert_hi_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bhe_n |=> cs_hi == '0);

  assert_unpopulated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !map_req && !POPULATED[a_set]) |=> (!claimed && cs_lo == '0 && cs_hi == '0));

  assert_withdrawn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !map_req && ems_mode && ems_claim[a_set] && int'(a_set) >= FIRST_DUAL)
      |=> (cs_lo == '0 && cs_hi == '0));

  assert_mapper_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_req && !ems_mode) |=> (!claimed && cs_lo == '0 && cs_hi == '0));

  assert_mapper_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (map_req && req && map_set != a_set) |=> (cs_lo[a_set] == 1'b0 && cs_hi[a_set] == 1'b0));

  assert_usable_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xms_usable & ~POPULATED) == '0);

  assert_one_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_d) && $onehot0(cs_lo | cs_hi));

  assert_claim_covers_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_lo | cs_hi) != '0) |-> claimed);

  assert_word_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> word_addr == $past(addr[ADDR_W-SET_W-1:1]));

endmodule

bind sram_set_decoder sram_set_decoder_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .FIRST_DUAL(FIRST_DUAL), .POPULATED(POPULATED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .bhe_n(bhe_n),
  .map_req(map_req), .map_set(map_set), .ems_mode(ems_mode), .ems_claim(ems_claim),
  .cs_lo(cs_lo), .cs_hi(cs_hi), .claimed(claimed), .xms_usable(xms_usable),
  .word_addr(word_addr), .sel_d(sel_d)
);

// File: tb/test_sram_set_decoder.sv
module test_sram_set_decoder;
  localparam logic [7:0] FITTED = 8'b0011_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic        bhe_n = 1'b1;
  logic        map_req = 1'b0;
  logic [2:0]  map_set = '0;
  logic        ems_mode = 1'b0;
  logic [7:0]  ems_claim = '0;
  logic [7:0]  cs_lo, cs_hi, xms_usable;
  logic        claimed;
  logic [19:0] word_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sram_set_decoder i_sram_set_decoder (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .bhe_n(bhe_n),
    .map_req(map_req), .map_set(map_set), .ems_mode(ems_mode), .ems_claim(ems_claim),
    .cs_lo(cs_lo), .cs_hi(cs_hi), .claimed(claimed), .xms_usable(xms_usable),
    .word_addr(word_addr)
  );

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Bench's own view of one access, computed from the requirements.
  task automatic access(input string tag, input logic r, input logic [23:0] a, input logic bh,
                        input logic m, input logic [2:0] ms, input logic e, input logic [7:0] c);
    logic [7:0] e_lo, e_hi, e_use;
    logic       hit;
    int         bank;
    @(negedge clk);
    req = r; addr = a; bhe_n = bh; map_req = m; map_set = ms; ems_mode = e; ems_claim = c;
    hit = 1'b0; bank = 0;
    for (int k = 0; k < 8; k++) e_use[k] = FITTED[k] && !(e && c[k] && k > 3);
    if (m) begin
      bank = int'(ms);
      hit = e && c[bank] && bank > 3 && FITTED[bank];
    end else if (r) begin
      bank = int'(a[23:21]);
      hit = e_use[bank];
    end
    e_lo = '0; e_hi = '0;
    if (hit && !a[0]) e_lo[bank] = 1'b1;
    if (hit && !bh)   e_hi[bank] = 1'b1;
    @(negedge clk);
    cmp({tag, " cs_lo"}, 32'(cs_lo), 32'(e_lo));
    cmp({tag, " cs_hi"}, 32'(cs_hi), 32'(e_hi));
    cmp({tag, " claimed"}, 32'(claimed), 32'(hit));
    cmp({tag, " usable"}, 32'(xms_usable), 32'(e_use));
    cmp({tag, " word"}, 32'(word_addr), 32'(a[20:1]));
    req = 1'b0; map_req = 1'b0;
  endtask

  function automatic logic [23:0] mk(input int bank, input logic [19:0] w, input logic a0);
    return {3'(bank), w, a0};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    req = 1'b1; addr = mk(0, 20'h12345, 1'b0); bhe_n = 1'b0;
    @(negedge clk);
    cmp("R1 cs_lo", 32'(cs_lo), 0);
    cmp("R1 cs_hi", 32'(cs_hi), 0);
    cmp("R1 claimed", 32'(claimed), 0);
    cmp("R1 usable", 32'(xms_usable), 0);
    cmp("R1 word", 32'(word_addr), 0);
    rst_n = 1'b1; req = 1'b0;
  endtask

  task automatic t_linear_sweep;  // R2 R4 R5
    for (int b = 0; b < 8; b++)
      access("R2_R4 sweep", 1'b1, mk(b, 20'(b * 20'h1111), 1'b0), 1'b0, 1'b0, 3'd0, 1'b0, 8'h00);
    access("R5 claims ignored", 1'b1, mk(5, 20'hABCDE, 1'b0), 1'b0, 1'b0, 3'd0, 1'b0, 8'hFF);
    access("R5 claims ignored b4", 1'b1, mk(4, 20'h00001, 1'b0), 1'b0, 1'b0, 3'd0, 1'b0, 8'hF0);
  endtask

  task automatic t_lanes;  // R3 R11
    access("R3 lo only", 1'b1, mk(0, 20'h0F0F0, 1'b0), 1'b1, 1'b0, 3'd0, 1'b0, 8'h00);
    access("R3 hi only", 1'b1, mk(0, 20'h0F0F1, 1'b1), 1'b0, 1'b0, 3'd0, 1'b0, 8'h00);
    access("R11 no lane", 1'b1, mk(4, 20'hFFFFF, 1'b1), 1'b1, 1'b0, 3'd0, 1'b0, 8'h00);
  endtask

  task automatic t_withdraw;  // R6 R7 R10
    access("R6 claimed b4", 1'b1, mk(4, 20'h22222, 1'b0), 1'b0, 1'b0, 3'd0, 1'b1, 8'h10);
    access("R6 unclaimed b5", 1'b1, mk(5, 20'h33333, 1'b0), 1'b0, 1'b0, 3'd0, 1'b1, 8'h10);
    access("R6_R10 both", 1'b1, mk(5, 20'h44444, 1'b0), 1'b0, 1'b0, 3'd0, 1'b1, 8'h30);
    access("R7 low claims", 1'b1, mk(0, 20'h55555, 1'b0), 1'b0, 1'b0, 3'd0, 1'b1, 8'h0F);
  endtask

  task automatic t_mapper;  // R8
    access("R8 mapped b5", 1'b0, mk(0, 20'h66666, 1'b0), 1'b0, 1'b1, 3'd5, 1'b1, 8'h20);
    access("R8 unclaimed", 1'b0, mk(0, 20'h66667, 1'b0), 1'b0, 1'b1, 3'd4, 1'b1, 8'h20);
    access("R8 mode off", 1'b0, mk(0, 20'h66668, 1'b0), 1'b0, 1'b1, 3'd5, 1'b0, 8'h20);
    access("R8 low bank", 1'b0, mk(0, 20'h66669, 1'b0), 1'b0, 1'b1, 3'd0, 1'b1, 8'h01);
    access("R8 unfitted", 1'b0, mk(0, 20'h6666A, 1'b0), 1'b0, 1'b1, 3'd6, 1'b1, 8'h40);
  endtask

  task automatic t_collision;  // R9
    access("R9 mapper wins", 1'b1, mk(0, 20'h77777, 1'b0), 1'b0, 1'b1, 3'd4, 1'b1, 8'h10);
    access("R9 reject no fallthrough", 1'b1, mk(0, 20'h77778, 1'b0), 1'b0, 1'b1, 3'd5, 1'b1, 8'h10);
  endtask

  task automatic t_word;  // R12
    access("R12 word", 1'b0, 24'hA5A5A4, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_linear_sweep();
    t_lanes();
    t_withdraw();
    t_mapper();
    t_collision();
    t_word();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule